// File: doc/BRIEF.md
# Priority Preemptive Flit Interleaver

This block decides, one flit slot at a time, which of several per-priority packet queues drives the link. Each queue shows its head flit with a valid bit, a first-flit marker and a last-flit marker. The block pops exactly one head per cycle, choosing the highest-numbered level that has a flit waiting. It forwards that flit one cycle later, together with its 5-bit level tag and a continuation bit for the downstream framer.

A packet at a higher level can take the link at any flit boundary, even when a lower level is partway through a packet. Each level keeps its own in-progress flag, so every interrupted packet picks up again from its next unsent flit once no higher level is waiting. Within one level, flits leave in queue order, so two packets of the same level never mix. When a level that is mid-packet runs dry, it gives up the slot in that same cycle to the next-lower level that has a flit.

Top module: `flit_interleaver`

## Requirements
- R1: While `rst_n` is low, `in_pop` is all zeros and `out_valid` is 0, whatever the inputs are.
- R2: In every cycle, `in_pop` is one-hot on the highest-index level whose `in_valid` bit is set, or all zeros when no level is valid.
- R3: A level with a flit waiting gets the next slot ahead of every lower level, even when a lower level is partway through a packet.
- R4: A preempted packet resumes with its next unsent flit. Each level's flits leave in queue order, so packets of the same level are never interleaved.
- R5: A flit popped in cycle t appears on `out_data` with `out_valid` high in cycle t+1. A newly arrived top-level flit therefore waits at most one flit slot.
- R6: `out_prio` carries the index of the level the output flit came from, as an unsigned 5-bit value.
- R7: `out_sop` and `out_eop` repeat the flit's markers. `out_cont` is 1 exactly when an earlier flit of the same packet has already been sent on that level.
- R8: When a level that is mid-packet has no flit waiting, the slot goes in that same cycle to the highest lower level that has one.
- R9: In the cycle after a cycle with no pop, `out_valid` is 0.
- R10: `NUM_LVL` must lie between 1 and 32, and `FLIT_W` must be at least 1. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_LVL | Head flit present, one bit per level |
| in_data | input | NUM_LVL*FLIT_W | Head flit payload; level l sits at bits [l*FLIT_W +: FLIT_W] |
| in_sop | input | NUM_LVL | Head flit is the first flit of its packet |
| in_eop | input | NUM_LVL | Head flit is the last flit of its packet |
| in_pop | output | NUM_LVL | Head of this level is consumed in this cycle |
| out_valid | output | 1 | Output flit present |
| out_data | output | FLIT_W | Output flit payload |
| out_sop | output | 1 | Output flit is the first flit of its packet |
| out_eop | output | 1 | Output flit is the last flit of its packet |
| out_cont | output | 1 | Output flit continues a packet already started on its level |
| out_prio | output | 5 | Level index of the output flit |

## Verification
The hardest case to reach is a stack of nested preemptions: two packets are suspended at different levels, and they must then resume in descending order with their continuation flags intact. A packet table sets this up. A level-1 packet is interrupted by a level-5 packet, and that packet is in turn interrupted by level 7 only a few cycles later. The same table also holds a packet whose later flits arrive after a delay, so its level runs dry mid-packet. A lower level then fills the gap, and the first packet completes after it.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   localparam int PRIO_W  = 5;
   localparam int MAX_LVL = 1 << PRIO_W;

   typedef logic [PRIO_W-1:0] prio_t;

   typedef struct packed {
      logic  sop;
      logic  eop;
      logic  cont;
      prio_t prio;
   } flit_tag_t;
endpackage

// File: rtl/ilv_prio_sel.sv
module ilv_prio_sel
   import ilv_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output prio_t        idx,
   output logic         any
);
   generate
      if (N == 1) begin : g_single
         assign grant = req;
         assign idx   = '0;
         assign any   = req[0];
      end else begin : g_multi
         always_comb begin
            grant = '0;
            idx   = '0;
            any   = 1'b0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) begin
                  grant    = '0;
                  grant[i] = 1'b1;
                  idx      = prio_t'(i);
                  any      = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      AST_GRANT_ONLY_REQ: assert ((grant & ~req) == '0); // R2
   end
endmodule

// File: rtl/ilv_lvl_track.sv
module ilv_lvl_track #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pop,
   input  logic [N-1:0] sop,
   input  logic [N-1:0] eop,
   output logic [N-1:0] mid
);
   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_lvl
         always_ff @(posedge clk) begin
            if (!rst_n)
               mid[g] <= 1'b0;
            else if (pop[g])
               mid[g] <= ~eop[g];
         end

         AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            pop[g] |-> (sop[g] == ~mid[g])); // R7
      end
   endgenerate
endmodule

// File: rtl/flit_interleaver.sv
module flit_interleaver
   import ilv_pkg::*;
#(
   parameter int NUM_LVL = 8,
   parameter int FLIT_W  = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_LVL-1:0]        in_valid,
   input  logic [NUM_LVL*FLIT_W-1:0] in_data,
   input  logic [NUM_LVL-1:0]        in_sop,
   input  logic [NUM_LVL-1:0]        in_eop,
   output logic [NUM_LVL-1:0]        in_pop,
   output logic                      out_valid,
   output logic [FLIT_W-1:0]         out_data,
   output logic                      out_sop,
   output logic                      out_eop,
   output logic                      out_cont,
   output logic [4:0]                out_prio
);
   generate
      if (NUM_LVL < 1 || NUM_LVL > MAX_LVL) begin : g_bad_lvl
         $error("flit_interleaver: NUM_LVL out of range 1..32"); // R10
      end
      if (FLIT_W < 1) begin : g_bad_w
         $error("flit_interleaver: FLIT_W must be positive"); // R10
      end
   endgenerate

   logic [NUM_LVL-1:0] grant;
   logic [NUM_LVL-1:0] mid;
   prio_t              sel_idx;
   logic               sel_any;

   ilv_prio_sel #(.N(NUM_LVL)) u_sel (
      .req   (in_valid),
      .grant (grant),
      .idx   (sel_idx),
      .any   (sel_any)
   );

   assign in_pop = rst_n ? grant : '0;

   ilv_lvl_track #(.N(NUM_LVL)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .pop   (in_pop),
      .sop   (in_sop),
      .eop   (in_eop),
      .mid   (mid)
   );

   logic [FLIT_W-1:0] lane [NUM_LVL];
   genvar g;
   generate
      for (g = 0; g < NUM_LVL; g++) begin : g_lane
         assign lane[g] = in_data[g*FLIT_W +: FLIT_W];
      end
   endgenerate

   logic [FLIT_W-1:0] data_sel;
   flit_tag_t         tag_sel;

   always_comb begin
      data_sel = '0;
      tag_sel  = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (grant[l]) begin
            data_sel     = lane[l];
            tag_sel.sop  = in_sop[l];
            tag_sel.eop  = in_eop[l];
            tag_sel.cont = mid[l];
         end
      end
      tag_sel.prio = sel_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_cont  <= 1'b0;
         out_prio  <= '0;
      end else begin
         out_valid <= sel_any;
         out_data  <= data_sel;
         out_sop   <= tag_sel.sop;
         out_eop   <= tag_sel.eop;
         out_cont  <= tag_sel.cont;
         out_prio  <= tag_sel.prio;
      end
   end

   always_comb begin
      if (!rst_n) AST_RESET_NO_POP: assert (in_pop == '0); // R1
   end

   AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_pop)); // R2
   AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pop & ~in_valid) == '0); // R2
   AST_POP_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_pop) |=> out_valid); // R5
   AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !(|in_pop) |=> !out_valid); // R9
   AST_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_prio) < NUM_LVL)); // R6
   AST_START_NOT_CONT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop) |-> !out_cont); // R7
endmodule

// File: tb/test_flit_interleaver.sv
module test_flit_interleaver;
   localparam int NL = 8;
   localparam int FW = 64;
   localparam int QD = 32;
   localparam int NPKT = 9;
   localparam int RUN = 70;

   // packet table: level, length, arrival cycle, first delayed flit, delay
   localparam int PKT [NPKT][5] = '{
      '{1, 6,  0, 15, 0},
      '{5, 3,  2, 15, 0},
      '{7, 2,  3, 15, 0},
      '{3, 4, 20,  2, 3},
      '{0, 5, 20, 15, 0},
      '{3, 2, 30, 15, 0},
      '{6, 1, 40, 15, 0},
      '{2, 3, 40, 15, 0},
      '{7, 4, 42, 15, 0}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NL-1:0]      in_valid = '0;
   logic [NL*FW-1:0]   in_data = '0;
   logic [NL-1:0]      in_sop = '0;
   logic [NL-1:0]      in_eop = '0;
   logic [NL-1:0]      in_pop;
   logic               out_valid;
   logic [FW-1:0]      out_data;
   logic               out_sop, out_eop, out_cont;
   logic [4:0]         out_prio;

   always #10 clk = ~clk;

   flit_interleaver #(.NUM_LVL(NL), .FLIT_W(FW)) i_flit_interleaver (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .in_pop(in_pop),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .out_cont(out_cont), .out_prio(out_prio)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [FW-1:0] q_data [NL][QD];
   bit            q_sop  [NL][QD];
   bit            q_eop  [NL][QD];
   int            q_rdy  [NL][QD];
   int            q_head [NL];
   int            q_tail [NL];
   bit            b_mid  [NL];

   bit            e_valid;
   logic [FW-1:0] e_data;
   bit            e_sop, e_eop, e_cont;
   int            e_prio;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk(out_valid == e_valid, "R5 R9", "out_valid", FW'(out_valid), FW'(e_valid));
      if (e_valid) begin
         chk(out_data == e_data, "R3 R4", "out_data", out_data, e_data);
         chk(int'(out_prio) == e_prio, "R6", "out_prio", FW'(out_prio), FW'(e_prio));
         chk(out_sop == e_sop && out_eop == e_eop, "R7", "markers",
             FW'({out_sop, out_eop}), FW'({e_sop, e_eop}));
         chk(out_cont == e_cont, "R7", "out_cont", FW'(out_cont), FW'(e_cont));
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int l = 0; l < NL; l++) begin
         q_head[l] = 0;
         q_tail[l] = 0;
         b_mid[l]  = 1'b0;
      end
      for (int p = 0; p < NPKT; p++) begin
         for (int k = 0; k < PKT[p][1]; k++) begin
            int l;
            int t;
            l = PKT[p][0];
            t = q_tail[l];
            q_data[l][t] = {8'(l), 8'(p), 8'(k), 40'h5A5A5A5A5A};
            q_sop[l][t]  = (k == 0);
            q_eop[l][t]  = (k == PKT[p][1] - 1);
            q_rdy[l][t]  = PKT[p][2] + ((k >= PKT[p][3]) ? PKT[p][4] : 0);
            q_tail[l]    = t + 1;
         end
      end

      // R1: reset with every level requesting
      @(negedge clk);
      in_valid = '1;
      in_sop   = '1;
      @(negedge clk);
      #1;
      chk(in_pop == '0, "R1", "pop in reset", FW'(in_pop), '0);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", FW'(out_valid), '0);
      in_valid = '0;
      in_sop   = '0;
      rst_n    = 1'b1;
      e_valid  = 1'b0;

      for (int cyc = 0; cyc < RUN; cyc++) begin
         logic [NL-1:0] vis;
         int            pick;
         @(negedge clk);
         check_outputs();
         vis  = '0;
         pick = -1;
         for (int l = 0; l < NL; l++) begin
            int h;
            h = q_head[l];
            if (h < q_tail[l] && q_rdy[l][h] <= cyc) begin
               vis[l] = 1'b1;
               in_data[l*FW +: FW] = q_data[l][h];
               in_sop[l] = q_sop[l][h];
               in_eop[l] = q_eop[l][h];
               pick = l;
            end else begin
               in_data[l*FW +: FW] = '0;
               in_sop[l] = 1'b0;
               in_eop[l] = 1'b0;
            end
         end
         in_valid = vis;
         #1;
         // R2 R3 R8: highest visible level is popped
         chk(in_pop == ((pick >= 0) ? (NL'(1) << pick) : '0), "R2 R3 R8", "in_pop",
             FW'(in_pop), FW'((pick >= 0) ? (NL'(1) << pick) : '0));
         e_valid = (pick >= 0);
         if (pick >= 0) begin
            int h;
            h = q_head[pick];
            e_data = q_data[pick][h];
            e_sop  = q_sop[pick][h];
            e_eop  = q_eop[pick][h];
            e_cont = b_mid[pick];
            e_prio = pick;
            b_mid[pick]  = !q_eop[pick][h];
            q_head[pick] = h + 1;
         end
      end
      in_valid = '0;
      @(negedge clk);
      check_outputs();
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "idle after drain", FW'(out_valid), '0);
      for (int l = 0; l < NL; l++)
         chk(q_head[l] == q_tail[l], "R4", "all flits delivered",
             FW'(q_head[l]), FW'(q_tail[l]));

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule